// File: doc/BRIEF.md
# DDR SDRAM Command Timing Monitor

This block watches the command bus of a four-bank DDR SDRAM without driving it. On every rising clock edge with clock-enable high and chip-select low it decodes the RAS/CAS/WE pins into a command. It tracks whether each bank is idle or holds an open row, and it counts clocks since the commands that later commands must respect. When a command breaks a minimum spacing, or is not allowed in the current bank state, it reports the problem.

Every timing limit is a clock-count parameter, so one instance covers any speed grade once the nanosecond figures are rounded up to clocks. The defaults suit a 7.5 ns clock. The burst length is a static input, because it sets where a write burst ends, and write recovery and write-to-read spacing count from that point. A detected problem raises `err` for one clock and sets a sticky bit in `reason`, with one bit per class of rule.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With cke high and cs_n low, {ras_n,cas_n,we_n} decodes as 000 mode-set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop and 111 no-op. `ba` selects bank 0..3. When cke is low or cs_n is high, nothing is decoded. A legal sequence raises no flag.
- R2: A read or write to an idle bank, an activate to an open bank, or a mode-set or refresh while any bank is open sets reason bit 0.
- R3: A read or write whose distance from the activate of its bank is below T_RCD sets bit 1. For a read with a10 high (auto-precharge), the limit is T_RAP instead.
- R4: An activate closer than T_RP to that bank's precharge sets bit 2. After a read with auto-precharge, the limit is counted from the read and is burst/2 + T_RP.
- R5: A precharge closer than T_RAS to the activate of a bank it closes sets bit 3. A bank that stays open for T_RAS_MAX+1 clocks sets bit 4.
- R6: Two activates to the same bank closer than T_RC set bit 5. Activates to different banks closer than T_RRD set bit 6.
- R7: Any command other than no-op within T_MRD clocks of a mode-set sets bit 7.
- R8: A precharge to an open bank closer than burst/2 + T_WR after a write to it sets bit 8. A read closer than burst/2 + T_WTR after any write sets bit 9.
- R9: After a write with a10 high, an activate to that bank closer than burst/2 + T_WR + T_RP sets bit 10. A read or write to that bank before burst/2 clocks have passed sets bit 11 instead of bit 0.
- R10: `err` is high in the cycle after an offending command, for one cycle per offence. `reason` bits are set in that same cycle.
- R11: `reason` bits are sticky until reset, and they change only when `err` is high.
- R12: A precharge with a10 high closes every open bank and ignores `ba`.
- R13: bl_sel 00, 01 and 1x select bursts of 2, 4 and 8 data words, so burst/2 is 1, 2 or 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank select |
| bl_sel | input | 2 | Burst length code |
| err | output | 1 | One-cycle violation pulse |
| reason | output | 12 | Sticky violation classes |

## Verification
The properties assume that bl_sel stays static between resets and that bus inputs are stable around the rising edge. The bench changes them only at falling edges and holds bl_sel for the whole of a scenario. The mode-set spacing property also assumes that the default T_MRD of 2 is in force. Each scenario begins from reset, so the sticky vector shows exactly the classes that this scenario triggered.

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor #(
  parameter int T_RCD     = 3,
  parameter int T_RAP     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RAS_MAX = 16000,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic        a10,
  input  logic [1:0]  bl_sel,
  output logic        err,
  output logic [11:0] reason
);
  localparam int NB = 4;
  localparam int NR = 12;
  localparam int CW = $clog2(T_RAS_MAX + 3);
  localparam logic [CW-1:0] SAT    = '1;
  localparam logic [CW-1:0] C_RCD  = CW'(T_RCD);
  localparam logic [CW-1:0] C_RAP  = CW'(T_RAP);
  localparam logic [CW-1:0] C_RP   = CW'(T_RP);
  localparam logic [CW-1:0] C_RAS  = CW'(T_RAS);
  localparam logic [CW-1:0] C_RASX = CW'(T_RAS_MAX + 1);
  localparam logic [CW-1:0] C_RC   = CW'(T_RC);
  localparam logic [CW-1:0] C_RRD  = CW'(T_RRD);
  localparam logic [CW-1:0] C_MRD  = CW'(T_MRD);
  localparam logic [CW-1:0] C_WR   = CW'(T_WR);
  localparam logic [CW-1:0] C_WTR  = CW'(T_WTR);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [2:0] op;
  logic live, is_mrs, is_ref, is_act, is_rd, is_wr, is_pre, is_any, is_col;
  assign live   = cke & ~cs_n;
  assign op     = {ras_n, cas_n, we_n};
  assign is_mrs = live & (op == 3'b000);
  assign is_ref = live & (op == 3'b001);
  assign is_act = live & (op == 3'b011);
  assign is_rd  = live & (op == 3'b101);
  assign is_wr  = live & (op == 3'b100);
  assign is_pre = live & (op == 3'b010);
  assign is_any = live & (op != 3'b111);
  assign is_col = is_rd | is_wr;

  logic [CW-1:0] half;
  always_comb begin
    case (bl_sel)
      2'b00:   half = CW'(1);
      2'b01:   half = CW'(2);
      default: half = CW'(4);
    endcase
  end

  logic [CW-1:0] act_cnt [NB];
  logic [CW-1:0] cls_cnt [NB];
  logic [CW-1:0] cls_need[NB];
  logic [CW-1:0] wr_cnt  [NB];
  logic [CW-1:0] any_act, any_wr, mrd_cnt;
  logic [NB-1:0] open_b, wap_b, dal_b;
  logic [1:0]    last_bk;

  logic [NB-1:0] tgt, ras_short, wr_short, ras_over;
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      tgt[i]       = a10 | (ba == 2'(i));
      ras_short[i] = open_b[i] & (act_cnt[i] < C_RAS);
      wr_short[i]  = open_b[i] & (wr_cnt[i] < half + C_WR);
      ras_over[i]  = open_b[i] & (act_cnt[i] == C_RASX);
    end
  end

  logic busy;
  logic [NR-1:0] v;
  assign busy = wap_b[ba] & (wr_cnt[ba] < half);

  always_comb begin
    v     = '0;
    v[0]  = (is_col & ~open_b[ba] & ~busy) | (is_act & open_b[ba])
          | ((is_mrs | is_ref) & (|open_b));
    v[1]  = is_col & open_b[ba] & (act_cnt[ba] < ((is_rd & a10) ? C_RAP : C_RCD));
    v[2]  = is_act & ~dal_b[ba] & (cls_cnt[ba] < cls_need[ba]);
    v[3]  = is_pre & (|(ras_short & tgt));
    v[4]  = |ras_over;
    v[5]  = is_act & (act_cnt[ba] < C_RC);
    v[6]  = is_act & (last_bk != ba) & (any_act < C_RRD);
    v[7]  = is_any & (mrd_cnt < C_MRD);
    v[8]  = is_pre & (|(wr_short & tgt));
    v[9]  = is_rd & (any_wr < half + C_WTR);
    v[10] = is_act & dal_b[ba] & (cls_cnt[ba] < cls_need[ba]);
    v[11] = is_col & ~open_b[ba] & busy;
  end

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] x);
    return (x == SAT) ? SAT : x + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        act_cnt[i]  <= SAT;
        cls_cnt[i]  <= SAT;
        cls_need[i] <= C_RP;
        wr_cnt[i]   <= SAT;
      end
      any_act <= SAT;
      any_wr  <= SAT;
      mrd_cnt <= SAT;
      open_b  <= '0;
      wap_b   <= '0;
      dal_b   <= '0;
      last_bk <= '0;
      err     <= 1'b0;
      reason  <= '0;
    end else begin
      any_act <= is_act ? ONE : inc(any_act);
      any_wr  <= is_wr  ? ONE : inc(any_wr);
      mrd_cnt <= is_mrs ? ONE : inc(mrd_cnt);
      if (is_act) last_bk <= ba;
      for (int i = 0; i < NB; i++) begin
        act_cnt[i] <= inc(act_cnt[i]);
        cls_cnt[i] <= inc(cls_cnt[i]);
        wr_cnt[i]  <= inc(wr_cnt[i]);
        if (ba == 2'(i)) begin
          if (is_act) begin
            act_cnt[i] <= ONE;
            open_b[i]  <= 1'b1;
            wap_b[i]   <= 1'b0;
            dal_b[i]   <= 1'b0;
          end
          if (is_wr) wr_cnt[i] <= ONE;
          if (is_col & a10 & open_b[i]) begin
            open_b[i]   <= 1'b0;
            cls_cnt[i]  <= ONE;
            cls_need[i] <= is_wr ? half + C_WR + C_RP : half + C_RP;
            dal_b[i]    <= is_wr;
            wap_b[i]    <= is_wr;
          end
        end
        if (is_pre & tgt[i] & open_b[i]) begin
          open_b[i]   <= 1'b0;
          cls_cnt[i]  <= ONE;
          cls_need[i] <= C_RP;
          dal_b[i]    <= 1'b0;
          wap_b[i]    <= 1'b0;
        end
      end
      err    <= |v;
      reason <= reason | v;
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic        err,
  input logic [11:0] reason
);
  logic live_cmd, mrs_cmd, prev_mrs;
  assign live_cmd = cke & ~cs_n & ({ras_n, cas_n, we_n} != 3'b111);
  assign mrs_cmd  = cke & ~cs_n & ({ras_n, cas_n, we_n} == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mrs <= 1'b0;
    else        prev_mrs <= mrs_cmd;
  end

  // R10
  err_has_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (reason != 12'h000));

  // R11
  sticky_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reason & $past(reason)) == $past(reason)));

  // R11
  reason_moves_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reason != $past(reason)) |-> err);

  // R7
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_mrs && live_cmd) |=> (err && reason[7]));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .err(err), .reason(reason));

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;
  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'b00, bl_sel = 2'b01;
  logic a10 = 1'b0;
  logic err;
  logic [11:0] reason;
  int n_chk = 0, n_bad = 0;

  localparam logic [3:0] ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;
  localparam logic [3:0] MRS = 4'b0000, REF = 4'b0001, NOP = 4'b0111;

  always #2 clk = ~clk;

  ddr_cmd_monitor uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .bl_sel(bl_sel), .err(err), .reason(reason));

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic ap);
    {cs_n, ras_n, cas_n, we_n} = c; ba = b; a10 = ap;
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    {cs_n, ras_n, cas_n, we_n} = NOP; a10 = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] bl);
    bl_sel = bl; cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = NOP; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_st(input string req, input logic e, input logic [11:0] r);
    n_chk++;
    if (err !== e || reason !== r) begin
      n_bad++;
      $display("FAIL %s: err=%0b reason=%03h expected err=%0b reason=%03h", req, err, reason, e, r);
    end
  endtask

  task automatic t_reset;
    do_reset(2'b01);
    expect_st("R10 reset state", 1'b0, 12'h000);
  endtask

  task automatic t_legal;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(RD, 2'd0, 1'b0); nop(2);
    issue(PRE, 2'd0, 1'b0); nop(2);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R1 legal sequence", 1'b0, 12'h000);
    cke = 1'b0;
    issue(RD, 2'd2, 1'b0);
    expect_st("R1 cke low ignored", 1'b0, 12'h000);
    cke = 1'b1;
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; ba = 2'd3;
    @(negedge clk);
    expect_st("R1 deselect ignored", 1'b0, 12'h000);
    nop(1);
  endtask

  task automatic t_state;
    do_reset(2'b01);
    issue(RD, 2'd2, 1'b0);
    expect_st("R2 read idle bank", 1'b1, 12'h001);
    nop(1);
    expect_st("R10 err single pulse", 1'b0, 12'h001);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(10);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R2 activate open bank", 1'b1, 12'h001);
    nop(1);
    do_reset(2'b01);
    issue(REF, 2'd0, 1'b0);
    expect_st("R2 refresh all idle", 1'b0, 12'h000);
    nop(2);
    issue(ACT, 2'd1, 1'b0); nop(2);
    issue(REF, 2'd0, 1'b0);
    expect_st("R2 refresh with open bank", 1'b1, 12'h001);
    nop(1);
  endtask

  task automatic t_rcd;
    do_reset(2'b01);
    issue(ACT, 2'd1, 1'b0);
    issue(RD, 2'd1, 1'b0);
    expect_st("R3 activate to read", 1'b1, 12'h002);
    nop(1);
    do_reset(2'b10);
    issue(ACT, 2'd0, 1'b0); nop(1);
    issue(RD, 2'd0, 1'b1);
    expect_st("R3 auto-precharge read early", 1'b1, 12'h002);
    nop(1);
  endtask

  task automatic t_rp;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(6);
    issue(PRE, 2'd0, 1'b0); nop(1);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R4 precharge to activate", 1'b1, 12'h004);
    nop(1);
    do_reset(2'b10);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(RD, 2'd0, 1'b1);
    expect_st("R4 auto-precharge read legal", 1'b0, 12'h000);
    nop(5);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R4 R13 reopen inside burst8 auto-close", 1'b1, 12'h004);
    nop(1);
  endtask

  task automatic t_ras;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(3);
    issue(PRE, 2'd0, 1'b0);
    expect_st("R5 activate to precharge min", 1'b1, 12'h008);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd3, 1'b0);
    nop(15990);
    expect_st("R5 open below max", 1'b0, 12'h000);
    nop(20);
    expect_st("R5 open beyond max", 1'b0, 12'h010);
  endtask

  task automatic t_rc_rrd;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(5);
    issue(PRE, 2'd0, 1'b0); nop(1);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R6 same-bank activate spacing", 1'b1, 12'h024);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0);
    issue(ACT, 2'd1, 1'b0);
    expect_st("R6 cross-bank activate spacing", 1'b1, 12'h040);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(1);
    issue(ACT, 2'd1, 1'b0);
    expect_st("R6 cross-bank spacing met", 1'b0, 12'h000);
    nop(1);
  endtask

  task automatic t_mrd;
    do_reset(2'b01);
    issue(MRS, 2'd0, 1'b0);
    issue(ACT, 2'd2, 1'b0);
    expect_st("R7 command after mode-set", 1'b1, 12'h080);
    nop(1);
    do_reset(2'b01);
    issue(MRS, 2'd0, 1'b0); nop(1);
    issue(ACT, 2'd2, 1'b0);
    expect_st("R7 mode-set spacing met", 1'b0, 12'h000);
    nop(1);
  endtask

  task automatic t_write;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b0); nop(2);
    issue(PRE, 2'd0, 1'b0);
    expect_st("R8 write recovery", 1'b1, 12'h100);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b0); nop(1);
    issue(RD, 2'd0, 1'b0);
    expect_st("R8 write to read", 1'b1, 12'h200);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b0); nop(2);
    issue(RD, 2'd0, 1'b0);
    expect_st("R8 write to read met", 1'b0, 12'h000);
    nop(1);
  endtask

  task automatic t_wap;
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b1); nop(5);
    issue(ACT, 2'd0, 1'b0);
    expect_st("R9 auto-precharge write to activate", 1'b1, 12'h400);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b1);
    issue(WR, 2'd0, 1'b0);
    expect_st("R9 column during auto-precharge burst", 1'b1, 12'h800);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b1); nop(2);
    issue(WR, 2'd0, 1'b0);
    expect_st("R9 column after auto-precharge burst", 1'b1, 12'h001);
    nop(1);
  endtask

  task automatic t_pre_all;
    do_reset(2'b01);
    issue(ACT, 2'd1, 1'b0); nop(6);
    issue(PRE, 2'd0, 1'b1); nop(2);
    issue(ACT, 2'd1, 1'b0);
    expect_st("R12 precharge-all reopen", 1'b0, 12'h000);
    nop(1);
    do_reset(2'b01);
    issue(ACT, 2'd1, 1'b0); nop(6);
    issue(PRE, 2'd0, 1'b1);
    issue(RD, 2'd1, 1'b0);
    expect_st("R12 precharge-all closed other bank", 1'b1, 12'h001);
    nop(1);
  endtask

  task automatic t_burst2;
    do_reset(2'b00);
    issue(ACT, 2'd0, 1'b0); nop(2);
    issue(WR, 2'd0, 1'b0); nop(1);
    issue(RD, 2'd0, 1'b0);
    expect_st("R13 burst2 write to read met", 1'b0, 12'h000);
    nop(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: err=%0b reason=%03h expected completion", err, reason);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_legal();
    t_state();
    t_rcd();
    t_rp();
    t_ras();
    t_rc_rrd();
    t_mrd();
    t_write();
    t_wap();
    t_pre_all();
    t_burst2();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule